// File: doc/BRIEF.md
# Sixteen-bit ALU with Flag Register and Branch Evaluator

This block is the arithmetic and logic unit of a two-address machine. Its two operands are A and B. Every operation except compare produces a value that the surrounding datapath writes back into the location that supplied operand A. The block covers add and subtract, both with and without carry. It also covers the bitwise logic operations, single-position shifts and rotates, and compare. A four-bit status register holds carry, zero, overflow and negative.

The result and its write strobe are combinational. They are valid in the same cycle that the operation is presented. The status register captures new flags on the rising clock edge, but only when an operation is valid and its flag-write enable is set. A separate three-bit condition input is decoded against the stored flags to give a branch-taken signal. Every ordered condition is a signed two's-complement decision, so a compare followed by a conditional branch implements the signed comparisons. Operand fetch and addressing belong to the surrounding datapath.

Top module: `alu16_alu`

## Requirements
- R1: Operation codes on `op_i` are ADD=0, SUB=1, ADC=2, SBC=3, AND=4, OR=5, XOR=6, NOT=7, SHL=8, SHR=9, ROL=10, ROR=11 and CMP=12.
  - ADD gives A+B. SUB gives A-B. ADC gives A+B+C. SBC gives A-B-C. Each result is taken modulo 2^16.
  - For add, C becomes the carry out. For subtract, C becomes 1 exactly when a borrow occurs, that is, when unsigned A < B plus the borrow in.
- R2: For ADD, ADC, SUB, SBC and CMP, V becomes 1 exactly when the exact signed result falls outside -32768..32767.
- R3: For every legal operation, Z becomes 1 when the 16-bit result is zero and N becomes bit 15 of the result.
  - `flags_o` is packed as {C, Z, V, N}, with C at bit 3 and N at bit 0.
- R4: AND, OR and XOR combine A with B bitwise. NOT inverts A and ignores B. All four clear C and V.
- R5: SHL shifts A left by one and fills bit 0 with zero. SHR shifts A right by one and fills bit 15 with zero. C receives the bit shifted out and V is cleared.
- R6: ROL moves bit 15 of A into bit 0. ROR moves bit 0 into bit 15. Both clear C and V, and neither reads C.
- R7: CMP sets all four flags exactly as SUB would on the same operands. It holds `result_we_o` low.
- R8: While `op_valid_i` is high, `result_we_o` is high in the same cycle for every legal operation other than CMP. Otherwise it is low.
- R9: The flags change only at a rising edge where `op_valid_i`, `flag_we_i` and a legal code are all present. In every other cycle they hold their value.
- R10: Codes 13 to 15 are ignored: `result_we_o` stays low and the flags are not changed.
- R11: `branch_taken_o` follows the stored flags in the same cycle, according to `cond_i`:
  - 0: always.
  - 1: Z.
  - 2: not Z.
  - 3: not Z and not (N xor V).
  - 4: not (N xor V).
  - 5: N xor V.
  - 6: Z or (N xor V).
  - 7: never.
- R12: After CMP A,B, condition 5 is taken exactly when signed A < signed B, condition 3 exactly when signed A > signed B, and condition 1 exactly when A equals B.
- R13: While `rst_ni` is low, all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | An operation is presented this cycle |
| op_i | input | 4 | Operation code |
| opa_i | input | 16 | First operand, which is also the destination |
| opb_i | input | 16 | Second operand |
| flag_we_i | input | 1 | Allow the flags to update for this operation |
| cond_i | input | 3 | Branch condition code |
| result_o | output | 16 | Operation result |
| result_we_o | output | 1 | Write strobe for the result |
| flags_o | output | 4 | Stored flags {C, Z, V, N} |
| branch_taken_o | output | 1 | Selected condition holds for the stored flags |

## Verification
The result, its strobe and the branch decision are due in the same cycle as their inputs. The bench therefore drives each operation just after a falling edge and samples these outputs one nanosecond later, before the next rising edge. Flags are due one edge later. The bench model updates its own flag copy only after that sample, so at every sample the stored flags are compared against the value the model held after the previous operation. The branch decision is checked in the same sample against that same previous value. Signed ordering is also checked directly against integer comparisons of the operands.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,  OP_SUB = 4'd1,  OP_ADC = 4'd2,  OP_SBC = 4'd3,
    OP_AND = 4'd4,  OP_OR  = 4'd5,  OP_XOR = 4'd6,  OP_NOT = 4'd7,
    OP_SHL = 4'd8,  OP_SHR = 4'd9,  OP_ROL = 4'd10, OP_ROR = 4'd11,
    OP_CMP = 4'd12
  } alu_op_e;

  typedef enum logic [2:0] {
    CC_ALW = 3'd0, CC_EQ = 3'd1, CC_NE = 3'd2, CC_GT = 3'd3,
    CC_GE  = 3'd4, CC_LT = 3'd5, CC_LE = 3'd6, CC_NEVER = 3'd7
  } cond_e;

  typedef struct packed {
    logic c;
    logic z;
    logic v;
    logic n;
  } flags_t;
endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_en_i,
  input  logic         cflag_i,
  output logic [W-1:0] sum_o,
  output logic         c_o,
  output logic         v_o
);
  logic [W:0] ext;
  logic       ci;

  always_comb begin
    ci = cin_en_i & cflag_i;
    if (sub_i) begin
      // a - b - ci == a + ~b + (1 - ci); carry out set means no borrow
      ext   = {1'b0, a_i} + {1'b0, ~b_i} + {{W{1'b0}}, ~ci};
      sum_o = ext[W-1:0];
      c_o   = ~ext[W];
      v_o   = (a_i[W-1] ^ b_i[W-1]) & (sum_o[W-1] ^ a_i[W-1]);
    end else begin
      ext   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, ci};
      sum_o = ext[W-1:0];
      c_o   = ext[W];
      v_o   = ~(a_i[W-1] ^ b_i[W-1]) & (sum_o[W-1] ^ a_i[W-1]);
    end
  end
endmodule

// File: rtl/alu16_bitops.sv
module alu16_bitops
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         c_o
);
  always_comb begin
    res_o = '0;
    c_o   = 1'b0;
    unique case (op_i)
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_NOT: res_o = ~a_i;
      OP_SHL: begin res_o = {a_i[W-2:0], 1'b0}; c_o = a_i[W-1]; end
      OP_SHR: begin res_o = {1'b0, a_i[W-1:1]}; c_o = a_i[0];   end
      OP_ROL: res_o = {a_i[W-2:0], a_i[W-1]};
      OP_ROR: res_o = {a_i[0], a_i[W-1:1]};
      default: ;
    endcase
  end
endmodule

// File: rtl/alu16_flag_reg.sv
module alu16_flag_reg
  import alu16_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   we_i,
  input  flags_t d_i,
  output flags_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/alu16_cond.sv
module alu16_cond
  import alu16_pkg::*;
(
  input  flags_t flags_i,
  input  cond_e  cond_i,
  output logic   taken_o
);
  logic lt;

  always_comb begin
    lt = flags_i.n ^ flags_i.v;
    unique case (cond_i)
      CC_ALW:   taken_o = 1'b1;
      CC_EQ:    taken_o = flags_i.z;
      CC_NE:    taken_o = ~flags_i.z;
      CC_GT:    taken_o = ~flags_i.z & ~lt;
      CC_GE:    taken_o = ~lt;
      CC_LT:    taken_o = lt;
      CC_LE:    taken_o = flags_i.z | lt;
      default:  taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu16_alu.sv
module alu16_alu
  import alu16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic              flag_we_i,
  input  logic [2:0]        cond_i,
  output logic [DATA_W-1:0] result_o,
  output logic              result_we_o,
  output logic [3:0]        flags_o,
  output logic              branch_taken_o
);
  localparam int MSB = DATA_W - 1;

  alu_op_e           op;
  logic              legal, is_arith, is_sub, cin_en;
  logic [DATA_W-1:0] sum, bit_res;
  logic              as_c, as_v, bo_c;
  flags_t            flags_q, flags_d;

  assign op = alu_op_e'(op_i);

  always_comb begin
    legal    = op_i <= 4'd12;
    is_sub   = op inside {OP_SUB, OP_SBC, OP_CMP};
    is_arith = op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP};
    cin_en   = op inside {OP_ADC, OP_SBC};
  end

  alu16_addsub #(.W(DATA_W)) u_addsub (
    .a_i      (opa_i),
    .b_i      (opb_i),
    .sub_i    (is_sub),
    .cin_en_i (cin_en),
    .cflag_i  (flags_q.c),
    .sum_o    (sum),
    .c_o      (as_c),
    .v_o      (as_v)
  );

  alu16_bitops #(.W(DATA_W)) u_bitops (
    .op_i  (op),
    .a_i   (opa_i),
    .b_i   (opb_i),
    .res_o (bit_res),
    .c_o   (bo_c)
  );

  always_comb begin
    result_o  = is_arith ? sum : bit_res;
    flags_d.c = is_arith ? as_c : bo_c;
    flags_d.v = is_arith & as_v;
    flags_d.z = (result_o == '0);
    flags_d.n = result_o[MSB];
  end

  assign result_we_o = op_valid_i & legal & (op != OP_CMP);

  alu16_flag_reg u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (op_valid_i & flag_we_i & legal),
    .d_i    (flags_d),
    .q_o    (flags_q)
  );

  alu16_cond u_cond (
    .flags_i (flags_q),
    .cond_i  (cond_e'(cond_i)),
    .taken_o (branch_taken_o)
  );

  assign flags_o = flags_q;
endmodule

// File: rtl/alu16_sva.sv
module alu16_sva #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_valid_i,
  input logic [3:0]        op_i,
  input logic              flag_we_i,
  input logic [2:0]        cond_i,
  input logic [DATA_W-1:0] result_o,
  input logic              result_we_o,
  input logic [3:0]        flags_o,
  input logic              branch_taken_o
);
  logic upd;
  assign upd = op_valid_i && flag_we_i && (op_i <= 4'd12);

  assert_cmp_no_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == 4'd12) |-> !result_we_o);

  assert_illegal_no_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > 4'd12) |-> !result_we_o);

  assert_flags_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd |=> $stable(flags_o));

  assert_zero_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> (flags_o[2] == ($past(result_o) == '0)));

  assert_neg_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |=> (flags_o[0] == $past(result_o[DATA_W-1])));

  assert_logic_clears_cv_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && op_i inside {4'd4, 4'd5, 4'd6, 4'd7, 4'd10, 4'd11}) |=> (flags_o[3] == 1'b0 && flags_o[1] == 1'b0));

  assert_always_taken_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == 3'd0) |-> branch_taken_o);

  assert_eq_follows_z_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == 3'd1) |-> (branch_taken_o == flags_o[2]));

  always_comb begin
    if (!rst_ni) assert_reset_flags_R13: assert (flags_o == 4'b0000);
  end
endmodule

bind alu16_alu alu16_sva #(.DATA_W(DATA_W)) u_sva (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .op_valid_i     (op_valid_i),
  .op_i           (op_i),
  .flag_we_i      (flag_we_i),
  .cond_i         (cond_i),
  .result_o       (result_o),
  .result_we_o    (result_we_o),
  .flags_o        (flags_o),
  .branch_taken_o (branch_taken_o)
);

// File: tb/alu16_alu_tb.sv
`timescale 1ns/1ps
module alu16_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op = '0;
  logic [15:0] opa = '0, opb = '0;
  logic        fwe = 1'b0;
  logic [2:0]  cond = '0;
  logic [15:0] result;
  logic        result_we;
  logic [3:0]  flags;
  logic        taken;

  int n_tests = 0;
  int n_fail  = 0;
  bit mc = 0, mz = 0, mv = 0, mn = 0;
  string prev_tag = "R13";

  always #2.5 clk = ~clk;

  alu16_alu u_dut (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_i(op),
    .opa_i(opa), .opb_i(opb), .flag_we_i(fwe), .cond_i(cond),
    .result_o(result), .result_we_o(result_we), .flags_o(flags),
    .branch_taken_o(taken)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit cond_model(input int c);
    bit lt = mn ^ mv;
    case (c)
      0: return 1;
      1: return mz;
      2: return !mz;
      3: return !mz && !lt;
      4: return !lt;
      5: return lt;
      6: return mz || lt;
      default: return 0;
    endcase
  endfunction

  function automatic int sx(input int x);
    return (x >= 32768) ? x - 65536 : x;
  endfunction

  // One cycle: drive after falling edge, sample 1 ns later, then advance model flags
  task automatic step(input bit vld, input int o, input int a, input int b,
                      input bit fw, input int c, input string tag);
    int r = 0, sr;
    bit nc = 0, nv = 0, legal, exp_we;
    @(negedge clk);
    op_valid = vld; op = o[3:0]; opa = a[15:0]; opb = b[15:0]; fwe = fw; cond = c[2:0];
    #1;
    legal = (o <= 12);
    case (o)
      0, 2: begin
        r = a + b + ((o == 2) ? int'(mc) : 0);
        nc = r > 65535;
        sr = sx(a) + sx(b) + ((o == 2) ? int'(mc) : 0);
        nv = (sr > 32767) || (sr < -32768);
      end
      1, 3, 12: begin
        r = a - b - ((o == 3) ? int'(mc) : 0);
        nc = r < 0;
        sr = sx(a) - sx(b) - ((o == 3) ? int'(mc) : 0);
        nv = (sr > 32767) || (sr < -32768);
      end
      4: r = a & b;
      5: r = a | b;
      6: r = a ^ b;
      7: r = ~a;
      8: begin r = a << 1; nc = a[15]; end
      9: begin r = a >> 1; nc = a[0]; end
      10: r = (a << 1) | (a >> 15);
      11: r = (a >> 1) | ((a & 1) << 15);
      default: r = 0;
    endcase
    r = r & 16'hFFFF;
    exp_we = vld && legal && (o != 12);
    if (vld && legal)
      check(result == r[15:0], tag, result, r);
    check(result_we == exp_we, "R8 result_we", result_we, exp_we);
    check(flags == {mc, mz, mv, mn}, {prev_tag, " flags"}, flags, {mc, mz, mv, mn});
    check(taken == cond_model(c), "R11 branch", taken, cond_model(c));
    if (vld && fw && legal) begin
      mc = nc; mv = nv; mz = (r == 0); mn = r[15];
      prev_tag = tag;
    end else begin
      prev_tag = vld ? "R10 hold" : "R9 hold";
    end
  endtask

  task automatic sweep();
    for (int c = 0; c < 8; c++) step(0, 0, 0, 0, 0, c, "R11");
  endtask

  task automatic signed_cmp(input int a, input int b);
    step(1, 12, a, b, 1, 0, "R7 cmp");
    step(0, 0, 0, 0, 0, 5, "R12");
    check(taken == (sx(a) < sx(b)), "R12 less", taken, sx(a) < sx(b));
    step(0, 0, 0, 0, 0, 3, "R12");
    check(taken == (sx(a) > sx(b)), "R12 greater", taken, sx(a) > sx(b));
    step(0, 0, 0, 0, 0, 1, "R12");
    check(taken == (a == b), "R12 equal", taken, a == b);
  endtask

  initial begin
    #12;
    check(flags == 4'b0000, "R13 reset", flags, 0);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0, "R13");
    step(1, 0, 16'h1234, 16'h0F0F, 1, 1, "R1 add");
    step(1, 0, 16'h7FFF, 16'h0001, 1, 5, "R2 add overflow");
    step(1, 0, 16'hFFFF, 16'h0001, 1, 1, "R1 add carry");
    step(1, 2, 16'h0010, 16'h0020, 1, 2, "R1 adc carry in");
    step(1, 1, 16'h0000, 16'h0001, 1, 5, "R1 sub borrow");
    step(1, 3, 16'h0010, 16'h0005, 1, 4, "R1 sbc borrow in");
    step(1, 1, 16'h8000, 16'h0001, 1, 6, "R2 sub overflow");
    step(1, 3, 16'h0005, 16'h0005, 1, 3, "R1 sbc no borrow");
    step(1, 4, 16'hF0F0, 16'hFF00, 1, 0, "R4 and");
    step(1, 5, 16'h00F0, 16'h0F00, 1, 0, "R4 or");
    step(1, 6, 16'hAAAA, 16'hAAAA, 1, 1, "R4 xor zero");
    step(1, 7, 16'h00FF, 16'h1234, 1, 0, "R4 not");
    step(1, 8, 16'h8001, 0, 1, 0, "R5 shl");
    step(1, 9, 16'h8001, 0, 1, 0, "R5 shr");
    step(1, 9, 16'h0002, 0, 1, 0, "R5 shr no carry");
    step(1, 0, 16'hFFFF, 16'h0001, 1, 0, "R1 set carry");
    step(1, 10, 16'h8001, 0, 1, 0, "R6 rol");
    step(1, 11, 16'h8001, 0, 1, 0, "R6 ror");
    step(1, 0, 16'h0001, 16'h0001, 0, 0, "R9 no flag write");
    step(1, 12, 16'h0003, 16'h0005, 1, 5, "R7 cmp");
    step(1, 13, 16'h0000, 16'h0000, 1, 0, "R10 op13");
    step(1, 15, 16'h1111, 16'h1111, 1, 0, "R10 op15");
    step(0, 0, 0, 0, 1, 0, "R9 invalid");
    sweep();
    signed_cmp(16'h8000, 16'h0001);
    signed_cmp(16'h0001, 16'h8000);
    signed_cmp(16'h7FFF, 16'hFFFF);
    signed_cmp(16'h1234, 16'h1234);
    signed_cmp(16'hFFFE, 16'hFFFF);
    sweep();
    step(0, 0, 0, 0, 0, 7, "R11 never");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule